// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the protocol front end of a byte-addressed nonvolatile memory of 8192 bytes. It acts as an SPI target in clock modes 0 and 3. It oversamples chip select, serial clock and serial input in the system clock domain. Each transfer is decoded as an 8-bit command, then a 16-bit address where the command needs one, then a data phase. Reads are fetched byte by byte over a one-cycle synchronous memory port and run on without limit. Write data is gathered in a page latch of 32 bytes that has a per-byte valid mask.

When a write transfer ends on a byte boundary, the engine raises a single-cycle commit request to the write controller. The request carries the page index, the mask and the latched page. The write-enable latch, the busy flag and the status byte are kept outside the block. The engine sends them pulse requests and reads back their current values. A hold input from the pause logic freezes the serial interface without losing its place in the transfer.

Top module: `spimem_cmd_engine`

## Requirements
- R1: The serial output enable is low whenever chip select is high. After reset, no command takes effect until a chip-select falling edge has been seen.
- R2: The first 8 bits after a chip-select fall form the command, MSB first, sampled on SCK rising edges. The codes are 0x01 status write, 0x02 array write, 0x03 array read, 0x04 write-enable clear, 0x05 status read, 0x06 write-enable set.
- R3: A read command takes a 16-bit address, MSB first, of which only the low 13 bits are used. The byte stored there is then driven on `so` MSB first, each bit changing after an SCK falling edge. This holds in mode 0 and in mode 3.
- R4: During a read the address advances after each byte shifted out, and 0x1FFF is followed by 0x0000.
- R5: Write-enable set and clear pulse `wel_set` or `wel_clr` on the chip-select rise only when exactly 8 bits were clocked. Any other bit count has no effect.
- R6: An array write is accepted only while `wel` is 1 and `busy` is 0. Each data byte lands in the page latch at the column given by the low 5 address bits. The column then increments and wraps within the page, so bytes beyond 32 overwrite earlier columns. Each written column sets its bit in `commit_mask`.
- R7: `commit_req` pulses for one cycle, with `commit_page` equal to address bits 12:5, only when chip select rises after one or more complete data bytes. A rise with a partial byte or with no data byte commits nothing.
- R8: While `busy` is 1, array read, array write and status write are refused and produce no memory access or pulse. Status read is still served, and `status_in` is sent repeatedly, once per byte.
- R9: A status write that is accepted pulses `sr_wr` on a byte-aligned chip-select rise, with `sr_data` equal to the first data byte. Later bytes are ignored.
- R10: An unrecognised command causes the rest of the transfer to be ignored. The output enable stays low and no pulse is raised.
- R11: While `hold_n` is low, SCK edges are ignored and the output enable is low. When it returns high, the transfer continues from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause enable from hold logic, low pauses the interface |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| busy | input | 1 | Internal write cycle in progress |
| wel | input | 1 | Current write-enable latch state |
| status_in | input | 8 | Status byte returned by status read |
| wel_set | output | 1 | Pulse: set write-enable latch |
| wel_clr | output | 1 | Pulse: clear write-enable latch |
| sr_wr | output | 1 | Pulse: write status byte |
| sr_data | output | 8 | Status byte to write |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the strobe |
| commit_req | output | 1 | Pulse: commit latched page |
| commit_page | output | ADDR_W-PAGE_AW | Page index to commit |
| commit_mask | output | 2**PAGE_AW | Columns written in the page |
| commit_data | output | 8*2**PAGE_AW | Latched page data, column 0 in the low byte |

## Verification
A bit counter that is off by one shows up at the ports at the end of the first transfer. A set, clear or status pulse goes missing, or a write commits on an unaligned rise. A wrong read pointer shows in the second data byte on `so`, or at the wrap at 0x1FFF. A page column that does not wrap within its page shows in `commit_mask` in the same commit. A state machine that does not reach its skip state leaks an output enable or a pulse within the same transfer, so every fault is visible before chip select rises again.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;

   typedef enum logic [3:0] {
      S_IDLE,     // deselected
      S_OPC,      // shifting command
      S_AHI,      // address high byte
      S_ALO,      // address low byte
      S_RDAT,     // array read data out
      S_STAT,     // status data out
      S_WDAT,     // array write data in
      S_WSR,      // status write data in
      S_WSR_DONE, // status byte captured
      S_END,      // latch command awaiting deselect
      S_SKIP      // ignore rest of transfer
   } eng_state_e;
endpackage

// File: rtl/spimem_in_sync.sv
module spimem_in_sync #(
   parameter int W      = 2,
   parameter bit REG_IN = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);
   generate
      if (REG_IN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur <= '0;
            else        cur <= d;
         end
      end else begin : g_pass
         assign cur = d;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cur;
   end
endmodule

// File: rtl/spimem_page_buf.sv
module spimem_page_buf #(
   parameter int AW = 5,
   localparam int NB = 1 << AW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] col,
   input  logic [7:0]    wdata,
   output logic [NB*8-1:0] data_o,
   output logic [NB-1:0]   mask_o
);
   generate
      for (genvar i = 0; i < NB; i++) begin : g_col
         localparam logic [AW-1:0] IDX = AW'(i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_o[i*8 +: 8] <= '0;
               mask_o[i]        <= 1'b0;
            end else if (clr) begin
               mask_o[i] <= 1'b0;
            end else if (we && col == IDX) begin
               data_o[i*8 +: 8] <= wdata;
               mask_o[i]        <= 1'b1;
            end
         end
      end
   endgenerate

   // R6: a written column is marked valid in the following cycle
   a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> mask_o[$past(col)]);
endmodule

// File: rtl/spimem_cmd_engine.sv
module spimem_cmd_engine
   import spimem_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int PAGE_AW = 5,
   parameter bit REG_IN  = 1'b1,
   localparam int PAGE_BYTES = 1 << PAGE_AW,
   localparam int PAGE_DW    = PAGE_BYTES * 8,
   localparam int PG_W       = ADDR_W - PAGE_AW
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sck,
   input  logic               si,
   input  logic               hold_n,
   output logic               so,
   output logic               so_oe,
   input  logic               busy,
   input  logic               wel,
   input  logic [7:0]         status_in,
   output logic               wel_set,
   output logic               wel_clr,
   output logic               sr_wr,
   output logic [7:0]         sr_data,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [7:0]         mem_rdata,
   output logic               commit_req,
   output logic [PG_W-1:0]    commit_page,
   output logic [PAGE_BYTES-1:0] commit_mask,
   output logic [PAGE_DW-1:0] commit_data
);
   localparam int HI_W = ADDR_W - 8;

   initial begin
      assert (ADDR_W >= 9 && ADDR_W <= 16) else $error("ADDR_W must be 9..16");
      assert (PAGE_AW >= 1 && PAGE_AW < ADDR_W) else $error("PAGE_AW out of range");
   end

   // ---------------- input sampling ----------------
   logic [1:0] cs_sck_cur, cs_sck_prev;
   logic       si_q;

   spimem_in_sync #(.W(2), .REG_IN(REG_IN)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({cs_n, sck}),
      .cur  (cs_sck_cur),
      .prev (cs_sck_prev)
   );

   generate
      if (REG_IN) begin : g_si_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) si_q <= 1'b0;
            else        si_q <= si;
         end
      end else begin : g_si_pass
         assign si_q = si;
      end
   endgenerate

   logic armed_q;
   logic cs_q, cs_fall, cs_rise, sck_en, sck_rise, sck_fall;
   assign cs_q     = cs_sck_cur[1];
   assign cs_fall  = !cs_q && cs_sck_prev[1];
   assign cs_rise  = cs_q && !cs_sck_prev[1];
   assign sck_en   = !cs_q && hold_n && armed_q;
   assign sck_rise = sck_en && cs_sck_cur[0] && !cs_sck_prev[0];
   assign sck_fall = sck_en && !cs_sck_cur[0] && cs_sck_prev[0];

   // ---------------- engine state ----------------
   eng_state_e        st_q;
   logic [2:0]        bcnt_q, obit_q;
   logic [6:0]        sreg_q;
   logic [7:0]        op_q, out_byte_q;
   logic [HI_W-1:0]   ahi_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [PAGE_AW-1:0] col_q;
   logic [1:0]        rd_pipe_q;
   logic              so_q, got_byte_q;

   logic [7:0] byte_in;
   logic       byte_done, lat_clr, lat_we;
   assign byte_in   = {sreg_q, si_q};
   assign byte_done = sck_rise && (bcnt_q == 3'd7);
   assign lat_clr   = byte_done && (st_q == S_ALO) && (op_q == OP_WRITE);
   assign lat_we    = byte_done && (st_q == S_WDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE;   armed_q <= 1'b0;  bcnt_q <= '0;   obit_q <= '0;
         sreg_q <= '0;     op_q <= '0;       out_byte_q <= '0;
         ahi_q <= '0;      ptr_q <= '0;      col_q <= '0;    rd_pipe_q <= '0;
         so_q <= 1'b0;     got_byte_q <= 1'b0;
         wel_set <= 1'b0;  wel_clr <= 1'b0;  sr_wr <= 1'b0;  sr_data <= '0;
         mem_rd_en <= 1'b0; mem_addr <= '0;  commit_req <= 1'b0;
      end else begin
         wel_set <= 1'b0; wel_clr <= 1'b0; sr_wr <= 1'b0;
         commit_req <= 1'b0; mem_rd_en <= 1'b0;
         rd_pipe_q <= {rd_pipe_q[0], 1'b0};
         if (rd_pipe_q[1]) out_byte_q <= mem_rdata;

         if (cs_fall) begin
            armed_q <= 1'b1;
            st_q    <= S_OPC;
            bcnt_q  <= '0;
            obit_q  <= '0;
            sreg_q  <= '0;
         end else if (cs_rise) begin
            if (bcnt_q == 3'd0) begin
               case (st_q)
                  S_END:      if (op_q == OP_WREN) wel_set <= 1'b1;
                              else                 wel_clr <= 1'b1;
                  S_WDAT:     commit_req <= got_byte_q;
                  S_WSR_DONE: sr_wr <= 1'b1;
                  default: ;
               endcase
            end
            st_q <= S_IDLE;
         end else if (sck_rise) begin
            bcnt_q <= bcnt_q + 3'd1;
            sreg_q <= byte_in[6:0];
            if (bcnt_q == 3'd7) begin
               case (st_q)
                  S_OPC: begin
                     op_q <= byte_in;
                     case (byte_in)
                        OP_READ:  st_q <= busy ? S_SKIP : S_AHI;
                        OP_WRITE: st_q <= (busy || !wel) ? S_SKIP : S_AHI;
                        OP_WRSR:  st_q <= (busy || !wel) ? S_SKIP : S_WSR;
                        OP_WREN, OP_WRDI: st_q <= S_END;
                        OP_RDSR: begin
                           st_q       <= S_STAT;
                           out_byte_q <= status_in;
                           obit_q     <= '0;
                        end
                        default:  st_q <= S_SKIP;
                     endcase
                  end
                  S_AHI: begin
                     ahi_q <= byte_in[HI_W-1:0];
                     st_q  <= S_ALO;
                  end
                  S_ALO: begin
                     ptr_q <= {ahi_q, byte_in};
                     if (op_q == OP_READ) begin
                        mem_rd_en <= 1'b1;
                        mem_addr  <= {ahi_q, byte_in};
                        rd_pipe_q <= 2'b01;
                        obit_q    <= '0;
                        st_q      <= S_RDAT;
                     end else begin
                        col_q      <= byte_in[PAGE_AW-1:0];
                        got_byte_q <= 1'b0;
                        st_q       <= S_WDAT;
                     end
                  end
                  S_WDAT: begin
                     col_q      <= col_q + 1'b1;
                     got_byte_q <= 1'b1;
                  end
                  S_WSR: begin
                     sr_data <= byte_in;
                     st_q    <= S_WSR_DONE;
                  end
                  S_END:   st_q <= S_SKIP;
                  default: ;
               endcase
            end
         end else if (sck_fall && (st_q == S_RDAT || st_q == S_STAT)) begin
            so_q   <= out_byte_q[3'd7 - obit_q];
            obit_q <= obit_q + 3'd1;
            if (obit_q == 3'd7) begin
               if (st_q == S_RDAT) begin
                  ptr_q     <= ptr_q + 1'b1;
                  mem_rd_en <= 1'b1;
                  mem_addr  <= ptr_q + 1'b1;
                  rd_pipe_q <= 2'b01;
               end else begin
                  out_byte_q <= status_in;
               end
            end
         end
      end
   end

   assign so          = so_q;
   assign so_oe       = !cs_q && hold_n && (st_q == S_RDAT || st_q == S_STAT);
   assign commit_page = ptr_q[ADDR_W-1:PAGE_AW];

   spimem_page_buf #(.AW(PAGE_AW)) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (lat_clr),
      .we    (lat_we),
      .col   (col_q),
      .wdata (byte_in),
      .data_o(commit_data),
      .mask_o(commit_mask)
   );

   // ---------------- assertions ----------------
   // R1: output never enabled while deselected
   a_r1_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !so_oe);
   // R1: nothing happens before the first chip-select fall
   a_r1_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !(wel_set || wel_clr || sr_wr || commit_req || mem_rd_en));
   // R5, R7, R9: at most one side-effect pulse per cycle
   a_r5_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wel_set, wel_clr, sr_wr, commit_req}));
   // R7: commit is a single-cycle pulse with data behind it
   a_r7_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> !commit_req);
   a_r7_commit_mask: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> (commit_mask != '0));
endmodule

// File: tb/spimem_cmd_engine_test.sv
module spimem_cmd_engine_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
   logic busy = 1'b0, wel = 1'b0;
   logic [7:0] status_in = 8'h00;
   logic so, so_oe, wel_set, wel_clr, sr_wr, mem_rd_en, commit_req;
   logic [7:0] sr_data;
   logic [12:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;
   logic [7:0] commit_page;
   logic [31:0] commit_mask;
   logic [255:0] commit_data;

   always #10 clk = ~clk;   // 50 MHz

   spimem_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .busy(busy), .wel(wel), .status_in(status_in),
      .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr), .sr_data(sr_data),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .commit_req(commit_req), .commit_page(commit_page),
      .commit_mask(commit_mask), .commit_data(commit_data)
   );

   function automatic logic [7:0] fmem(input logic [12:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
   endfunction

   // memory stand-in and pulse monitors
   int n_reads = 0, n_set = 0, n_clr = 0, n_srw = 0, n_commit = 0;
   logic oe_seen = 1'b0;
   logic [7:0] cap_sr = 8'h00, cap_page = 8'h00;
   logic [31:0] cap_mask = '0;
   logic [255:0] cap_data = '0;
   always @(posedge clk) begin
      if (mem_rd_en) begin mem_rdata <= fmem(mem_addr); n_reads++; end
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
      if (sr_wr) begin n_srw++; cap_sr <= sr_data; end
      if (commit_req) begin
         n_commit++; cap_page <= commit_page; cap_mask <= commit_mask; cap_data <= commit_data;
      end
      if (so_oe) oe_seen <= 1'b1;
   end

   int n_chk = 0, n_fail = 0;
   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   localparam int H = 5;
   logic mode3 = 1'b0;
   task automatic wt(input int n); repeat (n) @(negedge clk); endtask

   task automatic sel();
      sck = mode3; wt(H); cs_n = 1'b0; wt(H);
   endtask
   task automatic desel();
      if (!mode3) sck = 1'b0;
      wt(H); cs_n = 1'b1; wt(3 * H);
   endtask
   task automatic xbit(input logic b, output logic r, output logic oe);
      sck = 1'b0; si = b; wt(H); r = so; oe = so_oe; sck = 1'b1; wt(H);
   endtask
   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
      logic r, oe;
      oe_all = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         xbit(tx[i], r, oe); rx[i] = r; oe_all = oe_all & oe;
      end
   endtask

   // read vectors: [31] mode 3, [23:16] byte count, [15:0] address
   localparam logic [31:0] RD_TAB [4] = '{
      32'h0003_0000, 32'h8004_1FFE, 32'h0002_E123, 32'h8001_0ABC };

   logic [7:0] rx;
   logic oe, r1;
   int base;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // chip select held low across reset
      wt(5); rst_n = 1'b1; wt(2);
      check("R1 reset oe", so_oe, 0);
      check("R1 reset commit", commit_req, 0);
      xbyte(8'h06, rx, oe);                 // no CS fall yet
      cs_n = 1'b1; wt(3 * H);
      check("R1 unarmed WREN ignored", n_set, 0);

      // R2/R5 write-enable set and clear
      sel(); xbyte(8'h06, rx, oe); desel();
      check("R2 R5 WREN pulse", n_set, 1);
      sel(); xbyte(8'h04, rx, oe); desel();
      check("R5 WRDI pulse", n_clr, 1);
      sel(); xbyte(8'h06, rx, oe); xbit(1'b0, r1, oe); desel();
      check("R5 nine-bit WREN ignored", n_set, 1);

      // R11 hold in the middle of a command
      sel();
      for (int i = 7; i >= 4; i--) xbit(8'h06 >> i, r1, oe);
      hold_n = 1'b0;
      for (int i = 0; i < 3; i++) xbit(1'b1, r1, oe);
      hold_n = 1'b1;
      for (int i = 3; i >= 0; i--) xbit(8'h06 >> i, r1, oe);
      desel();
      check("R11 held edges ignored", n_set, 2);

      // R3/R4 read vectors, modes 0 and 3
      for (int e = 0; e < 4; e++) begin
         mode3 = RD_TAB[e][31];
         sel();
         xbyte(8'h03, rx, oe);
         xbyte(RD_TAB[e][15:8], rx, oe);
         xbyte(RD_TAB[e][7:0], rx, oe);
         for (int k = 0; k < int'(RD_TAB[e][23:16]); k++) begin
            xbyte(8'h00, rx, oe);
            check(k == 0 ? "R3 read byte" : "R4 sequential byte", rx,
                  fmem(13'(RD_TAB[e][12:0] + k)));
            check("R3 read oe", oe, 1);
         end
         desel();
         check("R1 oe after deselect", so_oe, 0);
      end
      mode3 = 1'b0;

      // R11 hold during status output
      status_in = 8'h3C;
      sel(); xbyte(8'h05, rx, oe); xbyte(8'h00, rx, oe);
      check("R8 status byte", rx, 8'h3C);
      hold_n = 1'b0; wt(3);
      check("R11 oe low in hold", so_oe, 0);
      hold_n = 1'b1; wt(3);
      check("R11 oe back after hold", so_oe, 1);
      desel();

      // R6 write refused without write enable
      wel = 1'b0;
      sel(); xbyte(8'h02, rx, oe); xbyte(8'h00, rx, oe); xbyte(8'h20, rx, oe);
      xbyte(8'hAA, rx, oe); desel();
      check("R6 write without wel", n_commit, 0);

      // R6/R7 short write crossing the page end
      wel = 1'b1;
      sel(); xbyte(8'h02, rx, oe); xbyte(8'h0A, rx, oe); xbyte(8'h1E, rx, oe);
      xbyte(8'h11, rx, oe); xbyte(8'h22, rx, oe); xbyte(8'h33, rx, oe); xbyte(8'h44, rx, oe);
      desel();
      check("R7 commit count", n_commit, 1);
      check("R7 commit page", cap_page, 8'h50);
      check("R6 commit mask wrap", cap_mask, 32'hC000_0003);
      check("R6 col30", cap_data[30*8 +: 8], 8'h11);
      check("R6 col31", cap_data[31*8 +: 8], 8'h22);
      check("R6 col0", cap_data[0 +: 8], 8'h33);
      check("R6 col1", cap_data[8 +: 8], 8'h44);

      // R6 34-byte write overwrites the first columns
      sel(); xbyte(8'h02, rx, oe); xbyte(8'h00, rx, oe); xbyte(8'h40, rx, oe);
      for (int k = 0; k < 34; k++) xbyte(8'(8'h80 + k), rx, oe);
      desel();
      check("R7 second commit", n_commit, 2);
      check("R7 page index", cap_page, 8'h02);
      check("R6 full mask", cap_mask, 32'hFFFF_FFFF);
      check("R6 overwritten col0", cap_data[0 +: 8], 8'hA0);
      check("R6 overwritten col1", cap_data[8 +: 8], 8'hA1);
      check("R6 col2 kept", cap_data[16 +: 8], 8'h82);
      check("R6 col31 kept", cap_data[31*8 +: 8], 8'h9F);

      // R7 unaligned and empty writes
      sel(); xbyte(8'h02, rx, oe); xbyte(8'h01, rx, oe); xbyte(8'h00, rx, oe);
      xbyte(8'h01, rx, oe); xbyte(8'h02, rx, oe);
      for (int i = 0; i < 3; i++) xbit(1'b1, r1, oe);
      desel();
      check("R7 partial byte no commit", n_commit, 2);
      sel(); xbyte(8'h02, rx, oe); xbyte(8'h01, rx, oe); xbyte(8'h00, rx, oe); desel();
      check("R7 no data no commit", n_commit, 2);

      // R9 status write
      sel(); xbyte(8'h01, rx, oe); xbyte(8'h8C, rx, oe); xbyte(8'h11, rx, oe); desel();
      check("R9 status write pulse", n_srw, 1);
      check("R9 status write data", cap_sr, 8'h8C);

      // R8 busy behaviour
      busy = 1'b1; status_in = 8'h83;
      sel(); xbyte(8'h05, rx, oe); xbyte(8'h00, rx, oe);
      check("R8 status while busy", rx, 8'h83);
      xbyte(8'h00, rx, oe);
      check("R8 status repeats", rx, 8'h83);
      desel();
      base = n_reads; oe_seen = 1'b0;
      sel(); xbyte(8'h03, rx, oe); xbyte(8'h00, rx, oe); xbyte(8'h10, rx, oe);
      xbyte(8'h00, rx, oe); desel();
      check("R8 read refused no access", n_reads - base, 0);
      check("R8 read refused oe", oe_seen, 0);
      sel(); xbyte(8'h02, rx, oe); xbyte(8'h00, rx, oe); xbyte(8'h10, rx, oe);
      xbyte(8'h55, rx, oe); desel();
      check("R8 write refused", n_commit, 2);
      sel(); xbyte(8'h01, rx, oe); xbyte(8'h00, rx, oe); desel();
      check("R8 status write refused", n_srw, 1);
      busy = 1'b0;

      // R10 unknown opcodes
      oe_seen = 1'b0; base = n_reads;
      sel(); xbyte(8'h9F, rx, oe); xbyte(8'h00, rx, oe); xbyte(8'h00, rx, oe); desel();
      sel(); xbyte(8'h83, rx, oe); xbyte(8'h00, rx, oe); xbyte(8'h00, rx, oe);
      xbyte(8'h00, rx, oe); desel();
      check("R10 unknown oe", oe_seen, 0);
      check("R10 unknown pulses", n_set + n_clr + n_srw + n_commit, 2 + 1 + 1 + 2);
      check("R10 unknown no read", n_reads - base, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule